// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block turns single-byte read and write requests from a host into the pin activity of an 8-bit NAND flash interface, for up to two chip selects. Each request names a chip and one of three regions on that chip. A write to the command region raises the command-latch pin, and a write to the address region raises the address-latch pin. Data-region accesses move a byte with neither latch pin raised. Every access runs through a setup phase, an active-strobe phase and a hold phase. Each phase lasts a number of system clock cycles that comes from a timing bus.

On writes, the data bus stays tristated for a programmable number of cycles from the start of the access before the write byte is driven. A read that follows a command-region or address-region access has its setup phase stretched, so that the read strobe keeps a minimum spacing from the latch activity. An active-low wait input stretches the strobe phase while it is held low. The timing bus is captured when a request is accepted, so changes on it apply only to later accesses.

Every timing field uses an N+1 encoding: a field value of N gives N+1 cycles.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, `req_ready` is 1, both chip enables are high, both latch pins are low, both strobes are high and `dq_oe` is 0.
- R2: The setup phase runs from the cycle after acceptance until the strobe goes low. It lasts `d_setup`+1 cycles for data-region accesses and `ca_setup`+1 cycles for command- and address-region accesses. Timing bus layout: [7:0] strobe, [15:8] d_setup, [23:16] d_hold, [31:24] ca_setup, [39:32] ca_hold, [47:40] hiz, [51:48] cmd_gap, [55:52] addr_gap.
- R3: The strobe phase lasts `strobe`+1 cycles when `nwait_i` stays high. `nwe_o` is the strobe for writes and `nre_o` the strobe for reads, and the two are never low together.
- R4: The hold phase lasts `d_hold`+1 cycles for the data region and `ca_hold`+1 cycles for the command and address regions. Chip enable and latch pins stay asserted until it ends, and the block is idle on the next cycle.
- R5: The N+1 encoding holds at both ends of an 8-bit field: a value of 0 gives 1 cycle and a value of 255 gives 256 cycles.
- R6: On a write, `dq_oe` is 0 for the first `hiz`+1 cycles of the access, capped at the length of the access. After that it is 1 until the access ends, with `dq_o` equal to the request byte. On a read, `dq_oe` is never 1.
- R7: A read whose previous access was to the command region has a setup phase of max(setup, `cmd_gap`)+1 cycles. After an address-region access the length is max(setup, `addr_gap`)+1 cycles. After a data-region access no gap applies.
- R8: During an access, only the chip enable selected by `req_cs` is low. Bit 0 of `nce_o` belongs to chip 0.
- R9: Region code 1 (command) raises `cle_o` and code 2 (address) raises `ale_o` for the whole access. Codes 0 and 3 are both data region, and neither latch pin rises for them.
- R10: Each cycle in which `nwait_i` is low during the strobe phase adds one cycle to that phase. The count resumes once the input is high again.
- R11: `req_ready` is 0 from acceptance until the access ends. A read gives exactly one `rsp_valid` pulse, in the last hold cycle, carrying the `dq_i` value present at the end of the strobe. A write gives no pulse.
- R12: Changes to `timing_cfg` after a request is accepted have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 1 | Chip select index |
| req_region | input | 2 | 0/3 data, 1 command, 2 address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read byte |
| timing_cfg | input | 56 | Packed timing fields (see R2) |
| nce_o | output | 2 | Active-low chip enables |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| nwe_o | output | 1 | Active-low write strobe |
| nre_o | output | 1 | Active-low read strobe |
| dq_o | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | 8 | Data bus input value |
| nwait_i | input | 1 | Active-low wait from the flash |

## Verification
A phase counter loaded with the wrong value, or a phase register that skips a state, shows up on the first access that uses that field. The bench sees it as a setup, strobe or hold length that is off by at least one cycle, measured edge to edge at the strobe pins. A tristate timer that is off shows as a `dq_oe` rise in the wrong cycle of a write. A stale previous-region record changes the setup length of the very next read. A snapshot taken in the wrong place shows as phase lengths that follow the new timing when it changes mid-access. Each fault is caught within the access in which it first matters, at most a few hundred cycles.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RG_DATA = 2'd0,
        RG_CMD  = 2'd1,
        RG_ADDR = 2'd2,
        RG_ALT  = 2'd3
    } region_e;

    // Packed timing bus, MSB first; each value N means N+1 cycles.
    typedef struct packed {
        logic [3:0] addr_gap;
        logic [3:0] cmd_gap;
        logic [7:0] hiz;
        logic [7:0] ca_hold;
        logic [7:0] ca_setup;
        logic [7:0] d_hold;
        logic [7:0] d_setup;
        logic [7:0] strobe;
    } timing_t;

    localparam int TIMING_W = $bits(timing_t);
    localparam int PHASE_CNT_W = 8;
    localparam int HIZ_CNT_W = 9;

endpackage

// File: rtl/nseq_downcnt.sv
`timescale 1ns/1ps
module nseq_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nseq_pin_map.sv
`timescale 1ns/1ps
module nseq_pin_map
    import nseq_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DATA_W = 8,
    parameter int CS_W   = 1
) (
    input  phase_e             phase,
    input  logic               wr,
    input  logic [CS_W-1:0]    cs,
    input  region_e            region,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               hiz_done,
    output logic [NUM_CS-1:0]  nce_o,
    output logic               cle_o,
    output logic               ale_o,
    output logic               nwe_o,
    output logic               nre_o,
    output logic [DATA_W-1:0]  dq_o,
    output logic               dq_oe
);
    logic busy;
    assign busy = (phase != PH_IDLE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        assign nce_o[g] = !(busy && (cs == CS_W'(g)));
    end

    assign cle_o = busy && (region == RG_CMD);
    assign ale_o = busy && (region == RG_ADDR);
    assign nwe_o = !((phase == PH_STROBE) && wr);
    assign nre_o = !((phase == PH_STROBE) && !wr);
    assign dq_oe = busy && wr && hiz_done;
    assign dq_o  = wdata;
endmodule

// File: rtl/nand_phase_seq.sv
`timescale 1ns/1ps
module nand_phase_seq
    import nseq_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DATA_W = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [CS_W-1:0]      req_cs,
    input  logic [1:0]           req_region,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [TIMING_W-1:0]  timing_cfg,
    output logic [NUM_CS-1:0]    nce_o,
    output logic                 cle_o,
    output logic                 ale_o,
    output logic                 nwe_o,
    output logic                 nre_o,
    output logic [DATA_W-1:0]    dq_o,
    output logic                 dq_oe,
    input  logic [DATA_W-1:0]    dq_i,
    input  logic                 nwait_i
);
    typedef struct packed {
        phase_e                 ph;
        logic                   wr;
        logic [CS_W-1:0]        cs;
        region_e                rg;
        region_e                prev;
        logic [DATA_W-1:0]      wdata;
        logic [DATA_W-1:0]      rdata;
        logic [PHASE_CNT_W-1:0] strobe_len;
        logic [PHASE_CNT_W-1:0] hold_len;
    } seq_t;

    seq_t st_d, st_q;

    timing_t cfg_in;
    assign cfg_in = timing_t'(timing_cfg);

    logic                   cnt_load, cnt_dec, cnt_zero;
    logic [PHASE_CNT_W-1:0] cnt_val, cnt_unused;
    logic                   hiz_load, hiz_dec, hiz_zero;
    logic [HIZ_CNT_W-1:0]   hiz_val, hiz_cnt;

    function automatic logic is_ca(input region_e r);
        return (r == RG_CMD) || (r == RG_ADDR);
    endfunction

    // Setup length including the latch-to-read spacing for reads.
    function automatic logic [PHASE_CNT_W-1:0] setup_len(
        input timing_t c, input region_e r, input logic w, input region_e p);
        logic [PHASE_CNT_W-1:0] len;
        len = is_ca(r) ? c.ca_setup : c.d_setup;
        if (!w) begin
            if ((p == RG_CMD) && ({4'b0, c.cmd_gap} > len)) begin
                len = {4'b0, c.cmd_gap};
            end
            if ((p == RG_ADDR) && ({4'b0, c.addr_gap} > len)) begin
                len = {4'b0, c.addr_gap};
            end
        end
        return len;
    endfunction

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        hiz_load = 1'b0;
        hiz_val  = '0;
        hiz_dec  = (st_q.ph != PH_IDLE);

        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph         = PH_SETUP;
                    st_d.wr         = req_write;
                    st_d.cs         = req_cs;
                    st_d.rg         = region_e'(req_region);
                    st_d.wdata      = req_wdata;
                    st_d.strobe_len = cfg_in.strobe;
                    st_d.hold_len   = is_ca(region_e'(req_region)) ? cfg_in.ca_hold
                                                                   : cfg_in.d_hold;
                    cnt_load = 1'b1;
                    cnt_val  = setup_len(cfg_in, region_e'(req_region), req_write, st_q.prev);
                    hiz_load = 1'b1;
                    hiz_val  = {1'b0, cfg_in.hiz} + HIZ_CNT_W'(1);
                end
            end
            PH_SETUP: begin
                cnt_dec = 1'b1;
                if (cnt_zero) begin
                    st_d.ph  = PH_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = st_q.strobe_len;
                end
            end
            PH_STROBE: begin
                cnt_dec = nwait_i;
                if (cnt_zero && nwait_i) begin
                    st_d.ph    = PH_HOLD;
                    st_d.rdata = dq_i;
                    cnt_load   = 1'b1;
                    cnt_val    = st_q.hold_len;
                end
            end
            PH_HOLD: begin
                cnt_dec = 1'b1;
                if (cnt_zero) begin
                    st_d.ph   = PH_IDLE;
                    st_d.prev = st_q.rg;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, wr: 1'b0, cs: '0, rg: RG_DATA, prev: RG_DATA,
                      wdata: '0, rdata: '0, strobe_len: '0, hold_len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    nseq_downcnt #(.W(PHASE_CNT_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt_unused),
        .zero     (cnt_zero)
    );

    nseq_downcnt #(.W(HIZ_CNT_W)) u_hiz_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hiz_load),
        .load_val (hiz_val),
        .dec      (hiz_dec),
        .cnt      (hiz_cnt),
        .zero     (hiz_zero)
    );

    nseq_pin_map #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .CS_W(CS_W)) u_pins (
        .phase    (st_q.ph),
        .wr       (st_q.wr),
        .cs       (st_q.cs),
        .region   (st_q.rg),
        .wdata    (st_q.wdata),
        .hiz_done (hiz_zero && (hiz_cnt == '0)),
        .nce_o    (nce_o),
        .cle_o    (cle_o),
        .ale_o    (ale_o),
        .nwe_o    (nwe_o),
        .nre_o    (nre_o),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe)
    );

    assign req_ready = (st_q.ph == PH_IDLE);
    assign rsp_valid = (st_q.ph == PH_HOLD) && cnt_zero && !st_q.wr;
    assign rsp_rdata = st_q.rdata;

    logic unused_ok;
    assign unused_ok = ^cnt_unused;
endmodule

// File: rtl/nseq_checker.sv
`timescale 1ns/1ps
module nseq_checker #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NUM_CS-1:0] nce_o,
    input logic              cle_o,
    input logic              ale_o,
    input logic              nwe_o,
    input logic              nre_o,
    input logic              dq_oe,
    input logic              nwait_i
);
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((nce_o == '1) && nwe_o && nre_o && !dq_oe && !cle_o && !ale_o));

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nwe_o && !nre_o));

    p_first_cycle_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !dq_oe);

    p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nre_o |-> !dq_oe);

    p_single_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nce_o) <= 1);

    p_strobe_needs_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nwe_o || !nre_o) |-> (nce_o != '1));

    p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    p_wait_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nre_o && !nwait_i) |=> !nre_o);

    p_wait_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nwe_o && !nwait_i) |=> !nwe_o);

    p_rsp_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind nand_phase_seq nseq_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .nce_o     (nce_o),
    .cle_o     (cle_o),
    .ale_o     (ale_o),
    .nwe_o     (nwe_o),
    .nre_o     (nre_o),
    .dq_oe     (dq_oe),
    .nwait_i   (nwait_i)
);

// File: tb/nand_phase_seq_tb.sv
`timescale 1ns/1ps
module nand_phase_seq_tb;
    import nseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_cs = '0;
    logic [1:0]  req_region = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    timing_t     cfg = '0;
    logic [TIMING_W-1:0] timing_cfg;
    logic [1:0]  nce_o;
    logic        cle_o, ale_o, nwe_o, nre_o, dq_oe;
    logic [7:0]  dq_o;
    logic [7:0]  dq_i = '0;
    logic        nwait_i = 1'b1;

    int nvec = 0;
    int nfail = 0;
    int prev_rg = 0;

    assign timing_cfg = cfg;

    always #2 clk = ~clk;

    nand_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cs(req_cs), .req_region(req_region), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .timing_cfg(timing_cfg),
        .nce_o(nce_o), .cle_o(cle_o), .ale_o(ale_o), .nwe_o(nwe_o), .nre_o(nre_o),
        .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .nwait_i(nwait_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic timing_t mk(input int ag, input int cg, input int hz, input int cah,
                                   input int cas, input int dh, input int ds, input int sb);
        timing_t t;
        t.addr_gap = 4'(ag); t.cmd_gap = 4'(cg); t.hiz = 8'(hz);
        t.ca_hold = 8'(cah); t.ca_setup = 8'(cas);
        t.d_hold = 8'(dh); t.d_setup = 8'(ds); t.strobe = 8'(sb);
        return t;
    endfunction

    task automatic run_access(input bit wr, input int cs, input int rg, input logic [7:0] wd,
                              input logic [7:0] rp, input int waitk, input bit chg);
        timing_t c;
        bit ca, stb;
        int base, exp_su, exp_st, exp_ho, exp_hz, tot;
        int su, st, ho, oelow, phs, wl, rsp_n, rsp_at, iter, bad_sel, bad_stb, bad_dq, busy_rdy;
        logic [7:0] rsp_d;
        c = cfg;
        ca = (rg == 1) || (rg == 2);
        base = ca ? int'(c.ca_setup) : int'(c.d_setup);
        if (!wr) begin
            if (prev_rg == 1 && int'(c.cmd_gap) > base) base = int'(c.cmd_gap);
            if (prev_rg == 2 && int'(c.addr_gap) > base) base = int'(c.addr_gap);
        end
        exp_su = base + 1;
        exp_st = int'(c.strobe) + 1 + waitk;
        exp_ho = (ca ? int'(c.ca_hold) : int'(c.d_hold)) + 1;
        tot = exp_su + exp_st + exp_ho;
        exp_hz = wr ? ((int'(c.hiz) + 1 < tot) ? int'(c.hiz) + 1 : tot) : tot;
        su = 0; st = 0; ho = 0; oelow = 0; phs = 0; wl = 0; rsp_n = 0; rsp_at = -1;
        iter = 0; bad_sel = 0; bad_stb = 0; bad_dq = 0; busy_rdy = 0; rsp_d = '0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cs = 1'(cs); req_region = 2'(rg);
        req_wdata = wd; dq_i = rp;
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) cfg = ~c;
        while (nce_o != 2'b11 && iter < 3000) begin
            if (wl > 0) begin
                wl--;
                if (wl == 0) nwait_i = 1'b1;
            end
            stb = !nwe_o || !nre_o;
            if (phs == 0 && stb) begin
                phs = 1;
                if (waitk > 0) begin nwait_i = 1'b0; wl = waitk; end
            end else if (phs == 1 && !stb) begin
                phs = 2;
            end
            if (phs == 0) su++; else if (phs == 1) st++; else ho++;
            if (!dq_oe) oelow++;
            if (nce_o != ~(2'b01 << cs)) bad_sel++;
            if (cle_o != (rg == 1) || ale_o != (rg == 2)) bad_sel++;
            if (stb && (wr ? nwe_o : nre_o)) bad_stb++;
            if (dq_oe && (!wr || dq_o != wd)) bad_dq++;
            if (req_ready) busy_rdy++;
            if (rsp_valid) begin rsp_n++; rsp_at = ho; rsp_d = rsp_rdata; end
            iter++;
            @(negedge clk);
        end
        nwait_i = 1'b1;
        if (chg) cfg = c;
        if (iter >= 3000) chk("R4 access never ended", iter, 0);
        chk(chg ? "R12 setup after timing change" : "R2 R7 setup cycles", su, exp_su);
        chk(chg ? "R12 strobe after timing change" : "R3 R10 strobe cycles", st, exp_st);
        chk(chg ? "R12 hold after timing change" : "R4 hold cycles", ho, exp_ho);
        chk("R6 tristate cycles", oelow, exp_hz);
        chk("R8 R9 select and latch pins", bad_sel, 0);
        chk("R3 strobe direction", bad_stb, 0);
        chk("R6 write data on bus", bad_dq, 0);
        chk("R11 ready low while busy", busy_rdy, 0);
        chk("R1 ready back at idle", int'(req_ready), 1);
        chk("R11 response pulse count", rsp_n, wr ? 0 : 1);
        if (!wr) begin
            chk("R11 response in last hold cycle", rsp_at, exp_ho);
            chk("R11 read data", int'(rsp_d), int'(rp));
        end
        prev_rg = rg;
    endtask

    initial begin
        #(4 * 190000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        timing_t sets [3];
        sets[0] = mk(0, 0, 0, 0, 0, 0, 0, 0);
        sets[1] = mk(7, 9, 6, 5, 1, 4, 2, 3);
        sets[2] = mk(2, 3, 0, 2, 12, 1, 5, 1);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 chip enables high", int'(nce_o), 3);
        chk("R1 latch pins low", int'(cle_o) + int'(ale_o), 0);
        chk("R1 strobes high", int'(nwe_o) + int'(nre_o), 2);
        chk("R1 bus released", int'(dq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", int'(req_ready), 1);

        // R2 R3 R4 R6 R7 R8 R9 R11: sweep over chips, regions and directions
        for (int s = 0; s < 3; s++) begin
            cfg = sets[s];
            for (int cs = 0; cs < 2; cs++) begin
                for (int rg = 0; rg < 4; rg++) begin
                    for (int w = 1; w >= 0; w--) begin
                        run_access(w[0], cs, rg, 8'(8'h3c + 17 * rg + cs),
                                   8'(8'ha5 ^ (s * 16 + rg * 4 + cs)), 0, 1'b0);
                    end
                end
            end
        end

        // R7: longest spacing after command and address latches
        cfg = mk(15, 15, 0, 0, 0, 0, 2, 0);
        run_access(1'b1, 0, 1, 8'h70, 8'h00, 0, 1'b0);
        run_access(1'b0, 0, 0, 8'h00, 8'h5a, 0, 1'b0);
        run_access(1'b1, 1, 2, 8'h11, 8'h00, 0, 1'b0);
        run_access(1'b0, 1, 0, 8'h00, 8'hc3, 0, 1'b0);

        // R10: wait input stretches the strobe
        cfg = sets[1];
        run_access(1'b0, 0, 0, 8'h00, 8'h96, 1, 1'b0);
        run_access(1'b1, 1, 0, 8'h42, 8'h00, 5, 1'b0);
        run_access(1'b1, 0, 1, 8'h90, 8'h00, 3, 1'b0);

        // R5: field extremes (256-cycle phases)
        cfg = mk(0, 0, 255, 0, 0, 0, 255, 255);
        run_access(1'b1, 0, 0, 8'he7, 8'h00, 0, 1'b0);
        cfg = mk(0, 0, 255, 255, 255, 255, 0, 0);
        run_access(1'b1, 1, 1, 8'h18, 8'h00, 0, 1'b0);
        run_access(1'b0, 1, 2, 8'h00, 8'h81, 0, 1'b0);

        // R12: timing changes mid-access are ignored
        cfg = sets[1];
        run_access(1'b1, 0, 0, 8'h2d, 8'h00, 0, 1'b1);
        run_access(1'b0, 1, 2, 8'h00, 8'h6b, 0, 1'b1);
        cfg = sets[2];
        run_access(1'b1, 1, 1, 8'hb4, 8'h00, 0, 1'b1);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule